// File: doc/BRIEF.md
# Strobed Serial Voice Port

This block moves one 8-bit voice sample in each direction per frame over a four-wire synchronous serial link: a serial data input, a serial data output with an output-enable, a bit clock and a framing strobe. A rising edge of the active-high strobe, which repeats at the frame rate, opens an eight-bit window. In that window the port shifts out the transmit byte and captures a receive byte. Transmit and receive always share that one window, so the slot position comes from the strobe alone and no channel-select setting has any effect on it.

Two timing modes are chosen by configuration inputs. In direct mode the block's clock is itself the link bit clock (rates of 512 kHz and up), so each clock cycle is one bit and the inputs are used without resynchronisation. In resync mode (slow links of 128 kHz or 256 kHz) the block runs from a fast master clock. The strobe and data input pass through two-flop synchronisers, and the bit timing is regenerated by dividing the master clock, realigned on every strobe. A two-bit rate code sets the divider. Outside the window the output is not driven. Each received byte is presented on a parallel register with a one-cycle valid pulse.

Top module: `svp_voice_port`

## Requirements
- R1: While `rst` is high, and from the first clock edge with `rst` high even in the middle of a window, `dout_oe` and `rx_valid` are 0. `rx_byte` is 0 after reset.
- R2: Each detected strobe rising edge enables the output for exactly 8 bit periods. `dout_oe` is 0 at all other times.
- R3: The transmit byte is sent MSB first, one bit per bit period, on `dout` while `dout_oe` is 1.
- R4: The received byte is assembled MSB first from `din`, one sample per bit period. It appears on `rx_byte`, and `rx_valid` pulses for exactly one clock, once per window, after the eighth sample.
- R5: With `cfg_async`=0 (direct mode) a bit period is one clock cycle. The window occupies the 8 cycles that begin one clock after the first edge that samples `stb_in` high. `din` is sampled at the end of each window cycle.
- R6: With `cfg_async`=1 (resync mode) `stb_in` and `din` pass through two flops. A bit period is 32 >> `cfg_rate` clocks (00:32, 01:16, 10:8, 11:4). `din` is sampled in the middle of each bit period.
- R7: A strobe held high beyond the window starts no second window. Only a new rising edge does.
- R8: Activity on `din` outside the window leaves `rx_byte` unchanged and produces no `rx_valid` pulse.
- R9: `tx_byte` is captured when the window opens. Changing it during the window does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock in direct mode, master clock in resync mode |
| rst | input | 1 | Synchronous active-high reset |
| cfg_async | input | 1 | 0 = direct mode, 1 = resync mode |
| cfg_rate | input | 2 | Divider code in resync mode: period = 32 >> code clocks |
| stb_in | input | 1 | Active-high framing strobe |
| din | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to send in the next window |
| dout | output | 1 | Serial transmit data, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Output enable; 0 means the pin is released |
| rx_byte | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` updates |

## Verification
The assertions assume that `cfg_async` and `cfg_rate` change only while no window is open. They also assume the strobe stays low for at least a clock before each rise, and that reset is held for at least two clocks. The bench changes configuration only after an idle gap between frames. It lowers the strobe and waits before each new frame, and holds reset for three cycles. In resync mode it keeps each `din` bit steady for a full bit period, aligned to the strobe, so the mid-period sample after the two-flop delay always lands on a settled value.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int SVP_BYTE_W = 8;
  localparam int SVP_BIT_W  = $clog2(SVP_BYTE_W);
  localparam int SVP_RATE_W = 2;
endpackage

// File: rtl/svp_cond.sv
// Input conditioning: optional synchroniser chain, strobe edge detect.
module svp_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  input  logic stb_in,
  input  logic din_in,
  output logic stb_rise,
  output logic din_c
);
  logic [STAGES-1:0] stb_sr;
  logic [STAGES-1:0] din_sr;
  logic              stb_c;
  logic              stb_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          stb_sr[i] <= 1'b0;
          din_sr[i] <= 1'b0;
        end else if (i == 0) begin
          stb_sr[i] <= stb_in;
          din_sr[i] <= din_in;
        end else begin
          stb_sr[i] <= stb_sr[(i == 0) ? 0 : i-1];
          din_sr[i] <= din_sr[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  // Direct mode: one register on the strobe for edge detection, raw data.
  assign stb_c = resync ? stb_sr[STAGES-1] : stb_sr[0];
  assign din_c = resync ? din_sr[STAGES-1] : din_in;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb_c;
  end

  assign stb_rise = stb_c & ~stb_q;

  // R7: a held strobe yields a single start event
  a_r7_single_rise: assert property (@(posedge clk) disable iff (rst)
    stb_rise |=> !stb_rise);
endmodule

// File: rtl/svp_timer.sv
// Bit timing: divider and bit counter, restarted by each strobe rise.
module svp_timer
  import svp_pkg::*;
#(
  parameter int BASE_DIV = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  resync,
  input  logic [SVP_RATE_W-1:0] rate,
  input  logic                  start,
  output logic                  active,
  output logic [SVP_BIT_W-1:0]  bit_cnt,
  output logic                  smp_tick,
  output logic                  adv_tick,
  output logic                  last_smp
);
  localparam int DIV_W = $clog2(BASE_DIV);
  localparam logic [SVP_BIT_W-1:0] LAST_BIT = SVP_BIT_W'(SVP_BYTE_W - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic [DIV_W-1:0] div_mid;

  assign div_last = resync ? DIV_W'((BASE_DIV >> rate) - 1) : '0;
  assign div_mid  = div_last >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (start) begin
      active  <= 1'b1;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (active) begin
      if (div_cnt == div_last) begin
        div_cnt <= '0;
        if (bit_cnt == LAST_BIT) active <= 1'b0;
        else                     bit_cnt <= bit_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign smp_tick = active && (div_cnt == div_mid);
  assign adv_tick = active && (div_cnt == div_last);
  assign last_smp = smp_tick && (bit_cnt == LAST_BIT);

  // R6: divider never runs past the programmed period
  a_r6_div_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> div_cnt <= div_last);
  // R2: window opens only on a start event
  a_r2_open_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(start));
  // R2: window closes only after the eighth bit period
  a_r2_close_after_eighth: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(rst)) |-> ($past(bit_cnt) == LAST_BIT && $past(adv_tick)));
endmodule

// File: rtl/svp_shift.sv
// Transmit and receive shift registers.
module svp_shift
  import svp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  active,
  input  logic                  smp_tick,
  input  logic                  adv_tick,
  input  logic                  last_smp,
  input  logic [SVP_BYTE_W-1:0] tx_byte,
  input  logic                  din_c,
  output logic                  tx_bit,
  output logic [SVP_BYTE_W-1:0] rx_byte,
  output logic                  rx_valid
);
  logic [SVP_BYTE_W-1:0] tx_sh;
  logic [SVP_BYTE_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst)           tx_sh <= '0;
    else if (start)    tx_sh <= tx_byte;
    else if (adv_tick) tx_sh <= tx_sh << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last_smp;
      if (smp_tick) rx_sh   <= {rx_sh[SVP_BYTE_W-2:0], din_c};
      if (last_smp) rx_byte <= {rx_sh[SVP_BYTE_W-2:0], din_c};
    end
  end

  assign tx_bit = tx_sh[SVP_BYTE_W-1];

  // R9: transmit register moves only at a bit boundary or a new start
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !adv_tick && !start) |=> $stable(tx_sh));
  // R4: valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R8: received byte changes only with a valid pulse
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !rx_valid |-> $stable(rx_byte));
endmodule

// File: rtl/svp_voice_port.sv
// Strobed serial voice port, top level.
module svp_voice_port
  import svp_pkg::*;
#(
  parameter int BASE_DIV    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_async,
  input  logic [SVP_RATE_W-1:0] cfg_rate,
  input  logic                  stb_in,
  input  logic                  din,
  input  logic [SVP_BYTE_W-1:0] tx_byte,
  output logic                  dout,
  output logic                  dout_oe,
  output logic [SVP_BYTE_W-1:0] rx_byte,
  output logic                  rx_valid
);
  logic                 start;
  logic                 din_c;
  logic                 active;
  logic [SVP_BIT_W-1:0] bit_cnt;
  logic                 smp_tick;
  logic                 adv_tick;
  logic                 last_smp;

  svp_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .resync(cfg_async),
    .stb_in(stb_in), .din_in(din),
    .stb_rise(start), .din_c(din_c)
  );

  svp_timer #(.BASE_DIV(BASE_DIV)) u_timer (
    .clk(clk), .rst(rst), .resync(cfg_async), .rate(cfg_rate),
    .start(start), .active(active), .bit_cnt(bit_cnt),
    .smp_tick(smp_tick), .adv_tick(adv_tick), .last_smp(last_smp)
  );

  svp_shift u_shift (
    .clk(clk), .rst(rst), .start(start), .active(active),
    .smp_tick(smp_tick), .adv_tick(adv_tick), .last_smp(last_smp),
    .tx_byte(tx_byte), .din_c(din_c),
    .tx_bit(dout), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  assign dout_oe = active;

  // R1: reset releases the output on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dout_oe && !rx_valid));
  // R4: a valid pulse follows the eighth sample
  a_r4_valid_after_last: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(smp_tick) && $past(bit_cnt) == 3'd7));
endmodule

// File: tb/svp_voice_port_tb.sv
module svp_voice_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_async = 1'b0;
  logic [1:0] cfg_rate = 2'b00;
  logic       stb_in = 1'b0;
  logic       din = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       dout, dout_oe, rx_valid;
  logic [7:0] rx_byte;

  always #5 clk = ~clk;

  svp_voice_port u_dut (
    .clk(clk), .rst(rst), .cfg_async(cfg_async), .cfg_rate(cfg_rate),
    .stb_in(stb_in), .din(din), .tx_byte(tx_byte),
    .dout(dout), .dout_oe(dout_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Monitor state
  int D = 1;
  int HALF = 0;
  int oe_idx = 0;
  int pulses = 0;
  logic [7:0] tx_got = 8'h00;
  logic [7:0] rx_last = 8'h00;

  // {async, rate[1:0], tx[7:0], rx[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 2'b00, 8'hA5, 8'h3C},
    {1'b0, 2'b00, 8'h01, 8'h80},
    {1'b1, 2'b11, 8'hC3, 8'h5A},
    {1'b1, 2'b10, 8'h81, 8'h7E},
    {1'b1, 2'b01, 8'hF0, 8'h0F},
    {1'b1, 2'b00, 8'h6D, 8'hB2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (dout_oe) begin
        if ((oe_idx % D) == HALF && (oe_idx / D) < 8) tx_got[7 - oe_idx / D] = dout;
        oe_idx++;
      end
      if (rx_valid) begin
        pulses++;
        rx_last = rx_byte;
      end
    end
  end

  task automatic run_frame(input bit as, input bit [1:0] rt, input bit [7:0] tx,
                           input bit [7:0] rx, input int extra, input bit flip_tx,
                           input bit toggle_after);
    int lead, slen, total;
    @(negedge clk);
    cfg_async = as;
    cfg_rate  = rt;
    tx_byte   = tx;
    din       = 1'b0;
    D    = as ? (32 >> rt) : 1;
    HALF = (D - 1) / 2;
    oe_idx = 0; pulses = 0; tx_got = 8'h00; rx_last = 8'h00;
    repeat (4) @(negedge clk);
    lead  = as ? 0 : 2;
    slen  = 8 * D + extra;
    total = lead + 8 * D + extra + 24;
    for (int n = 0; n < total; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 0) stb_in = 1'b1;
      if (n == slen) stb_in = 1'b0;
      if (n >= lead && ((n - lead) % D) == 0 && ((n - lead) / D) < 8)
        din = rx[7 - (n - lead) / D];
      if (flip_tx && n == lead + 2 * D) tx_byte = ~tx;
      if (toggle_after && n > lead + 8 * D + 2) din = n[0];
    end
    stb_in = 1'b0;
    din    = 1'b0;
    chk(as ? "R6 window length" : "R5 window length", oe_idx, 8 * D);
    chk("R2 enable count", oe_idx, 8 * D);
    chk(flip_tx ? "R9 tx held" : "R3 tx bits", tx_got, tx);
    chk(extra > 0 ? "R7 one pulse" : "R4 pulse count", pulses, 1);
    chk("R4 rx byte", rx_last, rx);
    if (toggle_after) chk("R8 rx held", rx_byte, rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", dout_oe, 0);
    chk("R1 valid in reset", rx_valid, 0);
    chk("R1 rx byte in reset", rx_byte, 0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][18], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 0, 0, 0);

    // R7: long strobe in both modes
    run_frame(1'b0, 2'b00, 8'h96, 8'h69, 30, 0, 0);
    run_frame(1'b1, 2'b11, 8'h3E, 8'hD1, 40, 0, 0);
    // R9: tx_byte changes mid-window
    run_frame(1'b0, 2'b00, 8'hE7, 8'h24, 0, 1, 0);
    run_frame(1'b1, 2'b10, 8'h5C, 8'hA3, 0, 1, 0);
    // R8: din toggling outside the window
    run_frame(1'b1, 2'b11, 8'h0F, 8'hC9, 0, 0, 1);
    run_frame(1'b0, 2'b00, 8'h11, 8'h9E, 0, 0, 1);

    // R1: reset in the middle of a window
    @(negedge clk);
    cfg_async = 1'b1; cfg_rate = 2'b11; tx_byte = 8'hFF;
    repeat (4) @(negedge clk);
    stb_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 window open before reset", dout_oe, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 oe dropped by reset", dout_oe, 0);
    repeat (2) @(negedge clk);
    stb_in = 1'b0;
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 no valid after reset", rx_valid, 0);
    chk("R1 rx byte cleared", rx_byte, 0);
    chk("R1 oe stays low", dout_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule